// File: doc/BRIEF.md
# Serial Shift Clock Source Generator

This block derives the bit-rate shift clock for a serial port from a single high-speed oscillator clock. A 2-bit source select chooses one of three fixed oscillator taps (divide by 4, 8 or 16) or the underflow of a reloadable down-counting timer. The timer's underflow is halved before use. Whichever source is chosen feeds a common divide-by-16 stage. The output of that stage is a one-cycle shift enable at the bit rate. Its input is also brought out as a tick at sixteen times the bit rate, for oversampling receivers.

In synchronous slave mode the divider chain is bypassed. The external serial clock is synchronized to the oscillator clock, and each of its rising edges becomes one shift enable. All division is done with clock enables on the one oscillator clock, so no derived clocks exist. Changing the source or the mode clears the halving and divide-by-16 stages, so the first period after a switch is a full period of the new source and never a runt.

Top module: `shclk_gen`

## Requirements
- R1: While `rstN` is low, `shiftEn` and `ovsTick` are low. After reset is released with `srcSel` = 00, the first `ovsTick` is seen 16 clocks after release and the first `shiftEn` is seen 256 clocks after release.
- R2: Fixed sources, by `srcSel` code: 10 gives an `ovsTick` every 4 clocks, 01 every 8 clocks, and 00 every 16 clocks.
- R3: With `srcSel` = 11, the timer supplies the source. Prescaler codes 0, 1, 2 and 3 divide the oscillator by P = 1, 2, 8 and 32. The timer underflows every P×(reload+1) clocks, and `ovsTick` comes every second underflow, every 2×P×(reload+1) clocks.
- R4: `shiftEn` comes once every 16 `ovsTick` pulses and in the same cycle as the 16th, so its period is 16 times the tick period.
- R5: Timer rate settings produce these `shiftEn` periods: prescaler 0 with reload 09h gives 320 clocks, prescaler 3 with reload 09h gives 10240 clocks, prescaler 0 with reload 03h gives 128 clocks, and prescaler 1 with reload BFh gives 12288 clocks.
- R6: With `slaveMode` high, each rising edge of `extClk` produces exactly one single-cycle `shiftEn` pulse. `extClk` is driven between clock edges, and the pulse is visible after the third rising clock edge that follows the change.
- R7: With `slaveMode` high, `srcSel` is ignored, `ovsTick` stays low, and falling edges of `extClk` produce no `shiftEn`.
- R8: A change of `srcSel` or `slaveMode` restarts the halving and divide-by-16 stages. After a switch of source, `shiftEn` is seen together with the 16th `ovsTick` of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every stage runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Source select: 11 timer, 10 osc/4, 01 osc/8, 00 osc/16 |
| slaveMode | input | 1 | High bypasses all division and uses `extClk` |
| tmrPresc | input | 2 | Timer prescaler code (ratios 1, 2, 8, 32) |
| tmrReload | input | 8 | Timer reload value |
| extClk | input | 1 | External serial clock, used in slave mode |
| shiftEn | output | 1 | One-cycle shift enable at the bit rate |
| ovsTick | output | 1 | One-cycle tick at 16 times the bit rate (low in slave mode) |

## Verification
The bench sweeps every prescaler code against several reloads, including reload zero, where the timer underflows on every prescaled tick. A design with a wrong prescaler ratio or an off-by-one reload would show a tick period different from 2×P×(reload+1). Each fixed tap and each rate setting is timed over whole periods, which exposes a missing halving stage (half the expected period) and a wrong final divider. A source switch is made partway through a divide-by-16 count. If the stages were not cleared, the enable would arrive after fewer than 16 new ticks. In slave mode the bench checks that the synchronizer latency is exactly three edges and that pulses are one cycle wide. It also checks that falling edges and select changes leave both outputs untouched.

// File: rtl/shclk_pkg.sv
package shclk_pkg;

  // Source select encodings (the two-bit code is fixed by the interface)
  typedef enum logic [1:0] {
    SRC_OSC16 = 2'b00,
    SRC_OSC8  = 2'b01,
    SRC_OSC4  = 2'b10,
    SRC_TMR   = 2'b11
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clrDiv;     // restart halving and divide-by-16 stages
    logic    slaveOn;    // bypass all division
    logic    slaveEdge;  // synchronized rising edge of the external clock
    srcSel_e src;        // active source
  } ctrlStrobe_t;

  // Prescaler ratio for a timer prescaler code
  function automatic int unsigned prescRatio(input logic [1:0] code);
    case (code)
      2'd0:    prescRatio = 1;
      2'd1:    prescRatio = 2;
      2'd2:    prescRatio = 8;
      default: prescRatio = 32;
    endcase
  endfunction

endpackage

// File: rtl/shclk_ctrl.sv
module shclk_ctrl
  import shclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  srcSel,
  input  logic        slaveMode,
  input  logic        extClk,
  output ctrlStrobe_t strb
);

  logic [1:0] selQ;
  logic       slaveQ;
  logic       syncA, syncB, syncPrev;

  // Remember the configuration so a change can be seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= SRC_OSC16;
      slaveQ <= 1'b0;
    end else begin
      selQ   <= srcSel;
      slaveQ <= slaveMode;
    end
  end

  // Two-flop synchronizer plus an edge-history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= extClk;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  always_comb begin
    strb.clrDiv    = (srcSel != selQ) || (slaveMode != slaveQ);
    strb.slaveOn   = slaveMode;
    strb.slaveEdge = slaveMode && syncB && !syncPrev;
    strb.src       = srcSel_e'(srcSel);
  end

  // R6
  // slave_pulse_single_chk
  slave_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.slaveEdge |=> !strb.slaveEdge);

endmodule

// File: rtl/shclk_dp.sv
module shclk_dp
  import shclk_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int OVS_DIV  = 16,
  parameter int TAP_CNT  = 3,
  parameter int PRE_MAX  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [1:0]       tmrPresc,
  input  logic [TMR_W-1:0] tmrReload,
  output logic             shiftEn,
  output logic             ovsTick
);

  localparam int OSC_W = TAP_CNT + 1;          // smallest tap divides by 4
  localparam int PRE_W = $clog2(PRE_MAX);
  localparam int OVS_W = $clog2(OVS_DIV);

  // ---------------- fixed oscillator taps ----------------
  logic [OSC_W-1:0]   oscCnt;
  logic [TAP_CNT-1:0] tapTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oscCnt <= '0;
    else       oscCnt <= oscCnt + 1'b1;
  end

  for (genvar g = 0; g < TAP_CNT; g++) begin : gTap
    assign tapTick[g] = &oscCnt[g+1:0];   // divide by 2^(g+2)
  end

  // ---------------- timer: prescaler ----------------
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             preTick;

  assign preLimit = PRE_W'(prescRatio(tmrPresc) - 1);
  assign preTick  = (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (preTick) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  // ---------------- timer: reloading down-counter ----------------
  logic [TMR_W-1:0] tmrCnt;
  logic             underflow;

  assign underflow = preTick && (tmrCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tmrCnt <= '0;
    else if (underflow) tmrCnt <= tmrReload;
    else if (preTick)   tmrCnt <= tmrCnt - 1'b1;
  end

  // ---------------- halving of the underflow ----------------
  logic half;
  logic tmrTick;

  assign tmrTick = underflow && half;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            half <= 1'b0;
    else if (strb.clrDiv) half <= 1'b0;
    else if (underflow)   half <= ~half;
  end

  // ---------------- source selection ----------------
  logic srcTick;
  logic masterTick;

  always_comb begin
    case (strb.src)
      SRC_OSC4:  srcTick = tapTick[0];
      SRC_OSC8:  srcTick = tapTick[1];
      SRC_OSC16: srcTick = tapTick[2];
      default:   srcTick = tmrTick;
    endcase
  end

  assign masterTick = srcTick && !strb.clrDiv && !strb.slaveOn;

  // ---------------- common divide-by-16 ----------------
  logic [OVS_W-1:0] divCnt;
  logic             masterShift;

  assign masterShift = masterTick && (divCnt == OVS_W'(OVS_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            divCnt <= '0;
    else if (strb.clrDiv || strb.slaveOn) divCnt <= '0;
    else if (masterTick)                  divCnt <= divCnt + 1'b1;
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovsTick <= 1'b0;
      shiftEn <= 1'b0;
    end else begin
      ovsTick <= masterTick;
      shiftEn <= strb.slaveOn ? strb.slaveEdge : masterShift;
    end
  end

  // R3
  // tmr_reload_chk
  tmr_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> (tmrCnt == $past(tmrReload)));

  // R8
  // clear_restart_chk
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDiv |=> (divCnt == '0) && !half);

  // R2
  // tap_single_chk
  tap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    tapTick[0] |=> !tapTick[0]);

endmodule

// File: rtl/shclk_gen.sv
module shclk_gen
  import shclk_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int OVS_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic             slaveMode,
  input  logic [1:0]       tmrPresc,
  input  logic [TMR_W-1:0] tmrReload,
  input  logic             extClk,
  output logic             shiftEn,
  output logic             ovsTick
);

  ctrlStrobe_t strb;

  shclk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcSel    (srcSel),
    .slaveMode (slaveMode),
    .extClk    (extClk),
    .strb      (strb)
  );

  shclk_dp #(
    .TMR_W   (TMR_W),
    .OVS_DIV (OVS_DIV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tmrPresc  (tmrPresc),
    .tmrReload (tmrReload),
    .shiftEn   (shiftEn),
    .ovsTick   (ovsTick)
  );

  // R7
  // slave_quiet_chk
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |=> !ovsTick);

  // R4
  // shift_aligned_chk
  shift_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && shiftEn && !$past(slaveMode)) |-> ovsTick);

endmodule

// File: tb/sim_shclk_gen.sv
module sim_shclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic       slaveMode = 1'b0;
  logic [1:0] tmrPresc = 2'b00;
  logic [7:0] tmrReload = 8'h00;
  logic       extClk = 1'b0;
  logic       shiftEn, ovsTick;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shclk_gen u0 (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .slaveMode(slaveMode),
    .tmrPresc(tmrPresc), .tmrReload(tmrReload), .extClk(extClk),
    .shiftEn(shiftEn), .ovsTick(ovsTick)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count negedges until the chosen output is seen high
  task automatic nextPulse(input bit useShift, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(useShift ? shiftEn : ovsTick) && n < limit);
  endtask

  // Skip two pulses to settle, then return one whole period
  task automatic period(input bit useShift, output int p);
    int d;
    nextPulse(useShift, 40000, d);
    nextPulse(useShift, 40000, d);
    nextPulse(useShift, 40000, p);
  endtask

  initial begin
    int p, n, ticks;
    int reloads[4] = '{0, 1, 2, 9};

    // R1: outputs during reset
    repeat (4) @(negedge clk);
    check("R1 shiftEn in reset", int'(shiftEn), 0);
    check("R1 ovsTick in reset", int'(ovsTick), 0);
    rstN = 1'b1;
    nextPulse(1'b0, 1000, n);
    check("R1 first ovsTick", n, 16);
    nextPulse(1'b1, 1000, p);
    check("R1 first shiftEn", n + p, 256);

    // R2 / R4: fixed taps
    for (int s = 0; s < 3; s++) begin
      logic [1:0] code;
      int tp;
      code = (s == 0) ? 2'b10 : (s == 1) ? 2'b01 : 2'b00;
      tp = 4 << s;
      srcSel = code;
      period(1'b0, p);
      check("R2 tap tick period", p, tp);
      period(1'b1, p);
      check("R4 tap shift period", p, 16 * tp);
    end

    // R3: timer sweep of prescaler codes and reloads
    srcSel = 2'b11;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        int ratio;
        ratio = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 8 : 32;
        tmrPresc  = 2'(c);
        tmrReload = 8'(reloads[r]);
        period(1'b0, p);
        check("R3 timer tick period", p, 2 * ratio * (reloads[r] + 1));
      end
    end

    // R5: rate examples
    tmrPresc = 2'd0; tmrReload = 8'h09; period(1'b1, p); check("R5 p0 r09", p, 320);
    tmrPresc = 2'd0; tmrReload = 8'h03; period(1'b1, p); check("R5 p0 r03", p, 128);
    tmrPresc = 2'd3; tmrReload = 8'h09; period(1'b1, p); check("R5 p3 r09", p, 10240);
    tmrPresc = 2'd1; tmrReload = 8'hBF; period(1'b1, p); check("R5 p1 rBF", p, 12288);

    // R8: switch source partway through a divide-by-16 count
    for (int k = 0; k < 2; k++) begin
      srcSel = 2'b00;
      nextPulse(1'b1, 2000, n);
      repeat (5) nextPulse(1'b0, 100, n);
      srcSel = (k == 0) ? 2'b10 : 2'b01;
      ticks = 0;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (ovsTick) ticks++;
      end while (!shiftEn && n < 2000);
      check("R8 ticks to first shift", ticks, 16);
      check("R8 shift with tick", int'(ovsTick), 1);
    end

    // R6 / R7: slave mode
    slaveMode = 1'b1;
    repeat (3) @(negedge clk);
    for (int e = 0; e < 4; e++) begin
      int seen;
      srcSel = 2'(e);
      extClk = 1'b1;
      @(negedge clk); check("R6 latency 1", int'(shiftEn), 0);
      @(negedge clk); check("R6 latency 2", int'(shiftEn), 0);
      @(negedge clk); check("R6 pulse at 3", int'(shiftEn), 1);
      @(negedge clk); check("R6 single cycle", int'(shiftEn), 0);
      repeat (2) @(negedge clk);
      extClk = 1'b0;
      seen = 0;
      repeat (8) begin
        @(negedge clk);
        seen += int'(shiftEn) + int'(ovsTick);
      end
      check("R7 falling edge quiet", seen, 0);
    end
    n = 0;
    srcSel = 2'b10;
    repeat (100) begin
      @(negedge clk);
      n += int'(ovsTick) + int'(shiftEn);
    end
    check("R7 no tick in slave", n, 0);

    // R8: leaving slave mode restarts the dividers
    slaveMode = 1'b0;
    srcSel = 2'b00;
    ticks = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (ovsTick) ticks++;
    end while (!shiftEn && n < 2000);
    check("R8 after slave exit", ticks, 16);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule